// File: doc/BRIEF.md
# Tiny 8-bit Fetch-Execute Sequencer

This block is a compact accumulator-machine controller. It fetches opcode and operand bytes from a synchronous single-port memory and executes a small set of classic 8-bit operations. Those operations are an accumulator add, a load of the first accumulator from an immediate byte, a store of that accumulator to a 16-bit absolute address, increment and decrement of single accumulators, and six relative branches. Each branch tests a single condition flag. Inside the block sit a 16-bit program counter, an instruction register, two accumulators, a holding register and a four-flag condition register. All transfers between them run over one internal bus in a fixed order per operation.

The memory is expected to return read data one clock after the address is presented. Writes take effect at the clock edge where the write strobe is high. A byte that is not a known opcode stops the sequencer for good and raises the halt output. After that, only a reset restarts execution. The condition register is visible on a 4-bit output so that the flag results can be observed.

Top module: `tiny8_core`

## Requirements
- R1: While reset is low, the write strobe, halt output and flags output are all 0 and the address output is 0x0000. After reset is released, the first fetch reads address 0x0000.
- R2: Opcode 0x86 followed by a data byte loads that byte into accumulator A. It sets N (bit 7 of the value) and Z (value is zero), clears V and leaves C unchanged.
- R3: Opcode 0xB7 followed by an address high byte and then a low byte writes A to that 16-bit address with exactly one write-strobe cycle. It sets N and Z from A, clears V and leaves C unchanged.
- R4: Opcode 0x1B first copies A into the holding register over the internal bus. In the next cycle it places A+B in A. C is the carry out, V is signed overflow, N and Z come from the sum, and B is unchanged.
- R5: Opcode 0x4C adds one to A. It sets N and Z, sets V only when A was 0x7F, and leaves C unchanged.
- R6: Opcode 0x5A subtracts one from B. It sets N and Z, sets V only when B was 0x80, and leaves C unchanged.
- R7: The branches are 0x27 (Z=1), 0x26 (Z=0), 0x2B (N=1), 0x2A (N=0), 0x25 (C=1) and 0x24 (C=0), each followed by a signed offset byte. When the condition holds, the next opcode is fetched from the address after the offset byte plus the sign-extended offset. Otherwise execution continues at the address after the offset byte.
- R8: Any other opcode raises the halt output. Once raised, halt stays high, no write occurs and the address output stays constant until reset.
- R9: The program counter advances by one for each opcode or operand byte consumed, so an opcode fetch is followed by a program counter one higher.
- R10: The flags output carries N, Z, V and C on bits 3, 2, 1 and 0.
- R11: An opcode fetch plus decode takes 2 cycles. Increment and decrement take 2 cycles, load takes 3, branch takes 3, add takes 4 and store takes 4. The store's write strobe is high in its fourth cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr_o | output | 16 | Memory address for the current cycle |
| mem_wdata_o | output | 8 | Write data (accumulator A) |
| mem_we_o | output | 1 | Write strobe for the current cycle |
| mem_rdata_i | input | 8 | Read data for the address presented one cycle earlier |
| halted_o | output | 1 | High once an unknown opcode has been met |
| flags_o | output | 4 | Condition register {N, Z, V, C} |

## Verification
The assertions check several things on every cycle. Halt is sticky and never accompanied by a write. Each write strobe directly follows the high-address cycle of a store. The program counter steps by one after each opcode fetch. The add's second step always follows the bus transfer of A into the holding register. Increment never disturbs C. Only the directed programs can show the arithmetic results and flag values. The same holds for the direction and target of taken and untaken branches, the exact cycle of a store, and a backward-branch loop that repeats increments and decrements. All of these are judged from the memory writes and the flags output.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int EXT_W  = ADDR_W - DATA_W;

    localparam logic [DATA_W-1:0] OPC_ABA  = 8'h1B;
    localparam logic [DATA_W-1:0] OPC_INCA = 8'h4C;
    localparam logic [DATA_W-1:0] OPC_DECB = 8'h5A;
    localparam logic [DATA_W-1:0] OPC_LDAI = 8'h86;
    localparam logic [DATA_W-1:0] OPC_STAE = 8'hB7;
    localparam logic [DATA_W-1:0] OPC_BEQ  = 8'h27;
    localparam logic [DATA_W-1:0] OPC_BNE  = 8'h26;
    localparam logic [DATA_W-1:0] OPC_BMI  = 8'h2B;
    localparam logic [DATA_W-1:0] OPC_BPL  = 8'h2A;
    localparam logic [DATA_W-1:0] OPC_BCS  = 8'h25;
    localparam logic [DATA_W-1:0] OPC_BCC  = 8'h24;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_LOAD,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_ABA_TMP,
        ST_ABA_SUM,
        ST_BRANCH,
        ST_HALT
    } seq_state_e;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_INC,
        ALU_DEC
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc_a;
        logic [DATA_W-1:0] acc_b;
        logic [DATA_W-1:0] temp;
        cc_flags_t         cc;
    } core_regs_t;

endpackage

// File: rtl/tiny8_alu.sv
module tiny8_alu
    import tiny8_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  cc_flags_t         cc_i,
    output logic [DATA_W-1:0] res_o,
    output cc_flags_t         cc_o
);
    localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, b_i};
        res_o    = a_i;
        cc_o     = cc_i;
        unique case (op_i)
            ALU_ADD: begin
                res_o  = wide_sum[DATA_W-1:0];
                cc_o.c = wide_sum[DATA_W];
                cc_o.v = (a_i[DATA_W-1] == b_i[DATA_W-1]) &&
                         (wide_sum[DATA_W-1] != a_i[DATA_W-1]);
            end
            ALU_INC: begin
                res_o  = a_i + ONE;
                cc_o.v = (a_i == POS_MAX);
            end
            ALU_DEC: begin
                res_o  = a_i - ONE;
                cc_o.v = (a_i == NEG_MIN);
            end
            default: begin
                res_o  = a_i;
                cc_o.v = 1'b0;
            end
        endcase
        cc_o.n = res_o[DATA_W-1];
        cc_o.z = (res_o == '0);
    end

endmodule

// File: rtl/tiny8_branch_cond.sv
module tiny8_branch_cond
    import tiny8_pkg::*;
(
    input  logic [DATA_W-1:0] opcode_i,
    input  cc_flags_t         cc_i,
    output logic              is_branch_o,
    output logic              take_o
);
    always_comb begin
        is_branch_o = 1'b1;
        take_o      = 1'b0;
        case (opcode_i)
            OPC_BEQ: take_o = cc_i.z;
            OPC_BNE: take_o = !cc_i.z;
            OPC_BMI: take_o = cc_i.n;
            OPC_BPL: take_o = !cc_i.n;
            OPC_BCS: take_o = cc_i.c;
            OPC_BCC: take_o = !cc_i.c;
            default: is_branch_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
    import tiny8_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              halted_o,
    output logic [3:0]        flags_o
);
    localparam logic [ADDR_W-1:0] PC_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

    core_regs_t        cur_q;
    core_regs_t        nxt_d;

    logic [DATA_W-1:0] bus_d;
    alu_op_e           alu_op_d;
    logic [DATA_W-1:0] alu_a_d;
    logic [DATA_W-1:0] alu_b_d;
    logic [DATA_W-1:0] alu_res;
    cc_flags_t         alu_cc;
    logic [DATA_W-1:0] br_opcode_d;
    logic              br_is;
    logic              br_take;
    logic [ADDR_W-1:0] br_offset;

    tiny8_alu u_alu (
        .op_i  (alu_op_d),
        .a_i   (alu_a_d),
        .b_i   (alu_b_d),
        .cc_i  (cur_q.cc),
        .res_o (alu_res),
        .cc_o  (alu_cc)
    );

    tiny8_branch_cond u_brc (
        .opcode_i    (br_opcode_d),
        .cc_i        (cur_q.cc),
        .is_branch_o (br_is),
        .take_o      (br_take)
    );

    assign br_opcode_d = (cur_q.state == ST_DECODE) ? mem_rdata_i : cur_q.ir;
    assign br_offset   = {{EXT_W{mem_rdata_i[DATA_W-1]}}, mem_rdata_i};

    always_comb begin
        nxt_d       = cur_q;
        mem_addr_o  = cur_q.pc;
        mem_wdata_o = cur_q.acc_a;
        mem_we_o    = 1'b0;
        bus_d       = '0;
        alu_op_d    = ALU_PASS;
        alu_a_d     = bus_d;
        alu_b_d     = cur_q.temp;

        unique case (cur_q.state)
            ST_FETCH: begin
                nxt_d.pc    = cur_q.pc + PC_STEP;
                nxt_d.state = ST_DECODE;
            end
            ST_DECODE: begin
                nxt_d.ir = mem_rdata_i;
                case (mem_rdata_i)
                    OPC_ABA: nxt_d.state = ST_ABA_TMP;
                    OPC_INCA: begin
                        alu_op_d    = ALU_INC;
                        alu_a_d     = cur_q.acc_a;
                        nxt_d.acc_a = alu_res;
                        nxt_d.cc    = alu_cc;
                        nxt_d.state = ST_FETCH;
                    end
                    OPC_DECB: begin
                        alu_op_d    = ALU_DEC;
                        alu_a_d     = cur_q.acc_b;
                        nxt_d.acc_b = alu_res;
                        nxt_d.cc    = alu_cc;
                        nxt_d.state = ST_FETCH;
                    end
                    OPC_LDAI: begin
                        nxt_d.pc    = cur_q.pc + PC_STEP;
                        nxt_d.state = ST_LOAD;
                    end
                    OPC_STAE: begin
                        nxt_d.pc    = cur_q.pc + PC_STEP;
                        nxt_d.state = ST_ADDR_HI;
                    end
                    default: begin
                        if (br_is) begin
                            nxt_d.pc    = cur_q.pc + PC_STEP;
                            nxt_d.state = ST_BRANCH;
                        end else begin
                            nxt_d.state = ST_HALT;
                        end
                    end
                endcase
            end
            ST_LOAD: begin
                bus_d       = mem_rdata_i;
                alu_a_d     = bus_d;
                nxt_d.acc_a = alu_res;
                nxt_d.cc    = alu_cc;
                nxt_d.state = ST_FETCH;
            end
            ST_ADDR_HI: begin
                nxt_d.temp  = mem_rdata_i;
                nxt_d.pc    = cur_q.pc + PC_STEP;
                nxt_d.state = ST_ADDR_LO;
            end
            ST_ADDR_LO: begin
                mem_addr_o  = {cur_q.temp, mem_rdata_i};
                mem_we_o    = 1'b1;
                alu_a_d     = cur_q.acc_a;
                nxt_d.cc    = alu_cc;
                nxt_d.state = ST_FETCH;
            end
            ST_ABA_TMP: begin
                bus_d       = cur_q.acc_a;
                nxt_d.temp  = bus_d;
                nxt_d.state = ST_ABA_SUM;
            end
            ST_ABA_SUM: begin
                bus_d       = cur_q.acc_b;
                alu_op_d    = ALU_ADD;
                alu_a_d     = cur_q.temp;
                alu_b_d     = bus_d;
                nxt_d.acc_a = alu_res;
                nxt_d.cc    = alu_cc;
                nxt_d.state = ST_FETCH;
            end
            ST_BRANCH: begin
                if (br_take) begin
                    nxt_d.pc = cur_q.pc + br_offset;
                end
                nxt_d.state = ST_FETCH;
            end
            default: nxt_d.state = ST_HALT;
        endcase

        if (!rst_n) begin
            mem_addr_o = RESET_PC;
            mem_we_o   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state <= ST_FETCH;
            cur_q.pc    <= RESET_PC;
            cur_q.ir    <= '0;
            cur_q.acc_a <= '0;
            cur_q.acc_b <= '0;
            cur_q.temp  <= '0;
            cur_q.cc    <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign halted_o = (cur_q.state == ST_HALT);
    assign flags_o  = cur_q.cc;

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> (halted_o && !mem_we_o));

    assert_store_after_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> ($past(cur_q.state) == ST_ADDR_HI));

    assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_FETCH) |=> (cur_q.pc == $past(cur_q.pc) + PC_STEP));

    assert_aba_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_ABA_SUM) |->
            (($past(cur_q.state) == ST_ABA_TMP) && (cur_q.temp == $past(cur_q.acc_a))));

    assert_inca_keeps_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_DECODE && mem_rdata_i == OPC_INCA) |=>
            (cur_q.cc.c == $past(cur_q.cc.c)));

endmodule

// File: tb/tb_tiny8_core.sv
`timescale 1ns/1ps
module tb_tiny8_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic        halted;
    logic [3:0]  flags;

    int errors = 0;
    int checks = 0;

    logic [7:0]  mem  [0:1023];
    logic [7:0]  prog [0:63];
    int          pl;
    int          cyc;
    int          wr_cnt;
    logic [15:0] wr_addr [0:7];
    logic [7:0]  wr_data [0:7];
    int          wr_cyc  [0:7];

    always #4 clk = ~clk;

    tiny8_core dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_rdata_i (mem_rdata),
        .halted_o    (halted),
        .flags_o     (flags)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= prog[i];
            mem_rdata <= 8'h00;
            cyc       <= 0;
            wr_cnt    <= 0;
        end else begin
            mem_rdata <= mem[mem_addr[9:0]];
            if (mem_we) begin
                mem[mem_addr[9:0]] <= mem_wdata;
                if (wr_cnt < 8) begin
                    wr_addr[wr_cnt] <= mem_addr;
                    wr_data[wr_cnt] <= mem_wdata;
                    wr_cyc[wr_cnt]  <= cyc;
                end
                wr_cnt <= wr_cnt + 1;
            end
            cyc <= cyc + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = 8'h00;
        pl = 0;
    endtask

    task automatic emit(input logic [7:0] b);
        prog[pl] = b;
        pl++;
    endtask

    task automatic run_prog();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (halted) break;
        end
        @(negedge clk);
    endtask

    task automatic chk_write(input int idx, input logic [15:0] a, input logic [7:0] d,
                             input string req);
        chk(wr_cnt > idx, req, "write count", wr_cnt, idx + 1);
        if (wr_cnt > idx) begin
            chk(wr_addr[idx] == a, req, "write address", wr_addr[idx], a);
            chk(wr_data[idx] == d, req, "write data", wr_data[idx], d);
        end
    endtask

    // R1: reset state and first fetch address
    task automatic t_reset();
        clear_prog();
        emit(8'h01);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_addr == 16'h0000, "R1", "reset address", mem_addr, 0);
        chk(!mem_we, "R1", "reset strobe", mem_we, 0);
        chk(!halted, "R1", "reset halt", halted, 0);
        chk(flags == 4'h0, "R1", "reset flags", flags, 0);
        rst_n = 1'b1;
        #1;
        chk(mem_addr == 16'h0000, "R1", "first fetch address", mem_addr, 0);
    endtask

    // R2 R3 R10 R11: load, store, flags and store timing
    task automatic t_load_store();
        clear_prog();
        emit(8'h86); emit(8'h3D); emit(8'hB7); emit(8'h23); emit(8'h46);
        emit(8'h86); emit(8'h00); emit(8'hB7); emit(8'h20); emit(8'h40);
        emit(8'h01);
        run_prog();
        chk_write(0, 16'h2346, 8'h3D, "R3");
        chk(wr_cyc[0] == 6, "R11", "load+store write cycle", wr_cyc[0], 6);
        chk_write(1, 16'h2040, 8'h00, "R3");
        chk(wr_cnt == 2, "R3", "single strobe per store", wr_cnt, 2);
        chk(flags == 4'b0100, "R3", "store zero flags", flags, 4'b0100);

        clear_prog();
        emit(8'h86); emit(8'h80); emit(8'h01);
        run_prog();
        chk(flags == 4'b1000, "R10", "load negative flags", flags, 4'b1000);

        // set C via add, then load: C must survive
        clear_prog();
        emit(8'h5A); emit(8'h86); emit(8'h01); emit(8'h1B);
        emit(8'h86); emit(8'h80); emit(8'h01);
        run_prog();
        chk(flags == 4'b1001, "R2", "load keeps C", flags, 4'b1001);

        clear_prog();
        emit(8'h4C); emit(8'hB7); emit(8'h20); emit(8'h00); emit(8'h01);
        run_prog();
        chk_write(0, 16'h2000, 8'h01, "R5");
        chk(wr_cyc[0] == 5, "R11", "inc+store write cycle", wr_cyc[0], 5);
    endtask

    // R4 R5: add with carry, increment keeping C
    task automatic t_add_carry();
        clear_prog();
        for (int i = 0; i < 30; i++) emit(8'h5A);
        emit(8'h86); emit(8'h3D); emit(8'h1B); emit(8'h01);
        run_prog();
        chk(flags == 4'b0001, "R4", "3D+E2 flags", flags, 4'b0001);

        clear_prog();
        for (int i = 0; i < 30; i++) emit(8'h5A);
        emit(8'h86); emit(8'h3D); emit(8'h1B); emit(8'hB7); emit(8'h21); emit(8'h00);
        emit(8'h4C); emit(8'h01);
        run_prog();
        chk_write(0, 16'h2100, 8'h1F, "R4");
        chk(flags == 4'b0001, "R5", "inc keeps C", flags, 4'b0001);
    endtask

    // R4 R6 R7 R9: backward loop builds B=80, then signed-overflow add
    task automatic t_loop_overflow(input bit stop_after_add);
        clear_prog();
        emit(8'h86); emit(8'h80);
        emit(8'h5A); emit(8'h4C); emit(8'h26); emit(8'hFC);
        emit(8'h86); emit(8'hBD); emit(8'h1B);
        if (stop_after_add) begin
            emit(8'h01);
        end else begin
            emit(8'hB7); emit(8'h20); emit(8'h10); emit(8'h5A); emit(8'h01);
        end
        run_prog();
        if (stop_after_add) begin
            chk(flags == 4'b0011, "R4", "BD+80 overflow flags", flags, 4'b0011);
            chk(wr_cnt == 0, "R7", "no stray write", wr_cnt, 0);
        end else begin
            chk_write(0, 16'h2010, 8'h3D, "R9");
            chk(flags == 4'b0011, "R6", "dec 80 overflow flags", flags, 4'b0011);
        end
    endtask

    // R5: increment overflow
    task automatic t_inc_overflow();
        clear_prog();
        emit(8'h86); emit(8'h7F); emit(8'h4C); emit(8'h01);
        run_prog();
        chk(flags == 4'b1010, "R5", "inc 7F flags", flags, 4'b1010);
        clear_prog();
        emit(8'h86); emit(8'h7F); emit(8'h4C); emit(8'hB7); emit(8'h20); emit(8'h20);
        emit(8'h01);
        run_prog();
        chk_write(0, 16'h2020, 8'h80, "R5");
    endtask

    // R7: one branch case
    task automatic t_branch(input logic [7:0] opc, input bit setc, input logic [7:0] v,
                            input bit exp_taken);
        clear_prog();
        if (setc) begin
            emit(8'h5A); emit(8'h86); emit(8'h01); emit(8'h1B);
        end
        emit(8'h86); emit(v);
        emit(opc); emit(8'h03);
        emit(8'hB7); emit(8'h30); emit(8'h00);
        emit(8'h86); emit(8'h55);
        emit(8'hB7); emit(8'h30); emit(8'h01);
        emit(8'h01);
        run_prog();
        if (exp_taken) begin
            chk(wr_cnt == 1, "R7", $sformatf("taken %0h write count", opc), wr_cnt, 1);
            chk_write(0, 16'h3001, 8'h55, "R7");
        end else begin
            chk(wr_cnt == 2, "R7", $sformatf("not taken %0h write count", opc), wr_cnt, 2);
            chk_write(0, 16'h3000, v, "R7");
            chk_write(1, 16'h3001, 8'h55, "R7");
        end
    endtask

    // R8: unknown opcode halts, sticky, quiet bus
    task automatic t_halt();
        logic [15:0] held;
        clear_prog();
        emit(8'h86); emit(8'h11); emit(8'hB7); emit(8'h20); emit(8'h30);
        emit(8'h01);
        emit(8'hB7); emit(8'h20); emit(8'h31);
        run_prog();
        chk(halted, "R8", "halt raised", halted, 1);
        chk(wr_cnt == 1, "R8", "writes before halt", wr_cnt, 1);
        held = mem_addr;
        repeat (10) @(negedge clk);
        chk(halted, "R8", "halt sticky", halted, 1);
        chk(mem_addr == held, "R8", "address frozen", mem_addr, held);
        chk(wr_cnt == 1, "R8", "no write after halt", wr_cnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_prog();
        t_reset();
        t_load_store();
        t_add_carry();
        t_loop_overflow(1'b1);
        t_loop_overflow(1'b0);
        t_inc_overflow();
        t_branch(8'h27, 1'b0, 8'h00, 1'b1);
        t_branch(8'h27, 1'b0, 8'h01, 1'b0);
        t_branch(8'h26, 1'b0, 8'h01, 1'b1);
        t_branch(8'h26, 1'b0, 8'h00, 1'b0);
        t_branch(8'h2B, 1'b0, 8'h80, 1'b1);
        t_branch(8'h2B, 1'b0, 8'h01, 1'b0);
        t_branch(8'h2A, 1'b0, 8'h01, 1'b1);
        t_branch(8'h2A, 1'b0, 8'h80, 1'b0);
        t_branch(8'h25, 1'b1, 8'h01, 1'b1);
        t_branch(8'h25, 1'b0, 8'h01, 1'b0);
        t_branch(8'h24, 1'b0, 8'h01, 1'b1);
        t_branch(8'h24, 1'b1, 8'h01, 1'b0);
        t_halt();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule